// File: doc/BRIEF.md
# Trigger-Matched Hit Window Event Packer

This block sits between a time digitizer and a readout link. Hits arrive as channel number plus timestamp and wait in a hit buffer. The timestamps come from the block's own free-running time counter, which it drives out on `time_now` so the digitizer can stamp its hits. When a trigger pulse arrives, the block records the counter value together with the external event and bunch numbers. It then builds one event on a 32-bit output stream: a header word, one data word for each hit whose time lies inside the matching window that ends at the trigger time, and a trailer word.

Before it starts an event, the block waits for a guard interval. The guard is the search window minus the matching window, and it gives late hits time to reach the buffer. While it scans, the block discards hits that are older than the window. It stops at the first hit that is newer than the window and leaves that hit in the buffer for later triggers. Triggers that arrive while an event is being built are held in a small queue. If the queue is full, the trigger is stored in a single reject slot and is answered with an empty event that carries the error bit. If the reject slot is also taken, the trigger is lost and the next trailer carries the error bit.

When matching is switched off, the block forwards every buffered hit as a data word, with no framing, and ignores triggers. On the output, a word is transferred on a clock edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the word is held unchanged. On the input, `hit_ready` falls when the buffer is full. The digitizer cannot stall, so a hit it offers while `hit_ready` is low is lost.

Top module: `twp_packer`

## Requirements
- R1: After reset, `out_valid` is 0, `hit_ready` is 1, and `time_now` counts up by one every clock cycle.
- R2: With matching on, a trigger sampled when `time_now` equals T keeps each hit at the head of the buffer whose time h satisfies T−W ≤ h < T, compared modulo 2^19, where W is `cfg_window`. Each kept hit becomes a data word {2'b01, digitizer ID[3:0], channel[6:0], time[18:0]}.
- R3: During the scan, a hit older than T−W is removed from the buffer without output. A hit at or after T ends the scan and stays in the buffer, where a later trigger can match it.
- R4: Each matched event is a header {2'b10, digitizer ID, event[11:0], bunch[11:0], 2'b00}, then its data words, then a trailer {2'b11, digitizer ID, error, 13'b0, count[11:0]}. The count field equals the number of data words in the event.
- R5: The event and bunch fields of the header are the values of `ev_id` and `bunch_id` in the cycle when the trigger was sampled.
- R6: The header of a queued trigger is not presented before `time_now` − T ≥ `cfg_search` − `cfg_window`.
- R7: With matching off, every buffered hit is output in arrival order as a data word, with no header or trailer. A trigger pulse produces no output.
- R8: `hit_ready` is 0 when the hit buffer is full. A hit offered then is lost, and the next trailer has its error bit set. The trailer after that has the error bit clear if nothing else went wrong in between.
- R9: A trigger that finds the queue full goes to the reject slot. It is answered with an empty event: its own header, then a trailer with the error bit set and count 0. That empty event is emitted before the triggers still waiting in the queue.
- R10: A trigger that finds both the queue and the reject slot full is dropped, and the next trailer emitted has the error bit set.
- R11: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` does not change.
- R12: Data words of an event appear in the order in which the hits were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| match_en | input | 1 | 1: trigger-matched events; 0: raw forwarding |
| cfg_window | input | 19 | Matching window length in clock ticks |
| cfg_search | input | 19 | Search window length; at least `cfg_window` |
| trig | input | 1 | Trigger pulse |
| ev_id | input | 12 | Event number, sampled with the trigger |
| bunch_id | input | 12 | Bunch number, sampled with the trigger |
| time_now | output | 19 | Free-running time counter |
| hit_valid | input | 1 | Hit offered |
| hit_ready | output | 1 | Hit buffer has space |
| hit_chan | input | 7 | Hit channel number |
| hit_time | input | 19 | Hit timestamp |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Sink accepts the word |
| out_data | output | 32 | Output word |

## Verification
The bench builds the block with a four-entry hit buffer and a two-entry trigger queue. With these sizes, five back-to-back hits overflow the buffer, and five triggers on consecutive cycles fill the queue and the reject slot and then lose one trigger. The window is set to 40 ticks and the search window to 50, which gives a 10-tick guard. With this setting, the bench places hits exactly on both window edges and one tick outside each edge. It also checks that a newer hit stays in the buffer by matching it with a second trigger.

// File: rtl/twp_pkg.sv
package twp_pkg;
  localparam int WORD_W = 32;
  localparam int TIME_W = 19;
  localparam int CHAN_W = 7;
  localparam int EVID_W = 12;
  localparam int BID_W  = 12;
  localparam int CNT_W  = 12;
  localparam int DIG_W  = 4;
  localparam int PAD_W  = WORD_W - 2 - DIG_W - 1 - CNT_W;

  localparam logic [1:0] TAG_HDR = 2'b10;
  localparam logic [1:0] TAG_DAT = 2'b01;
  localparam logic [1:0] TAG_TRL = 2'b11;

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_HDR, S_SCAN, S_TRL} pk_state_t;

  function automatic logic [WORD_W-1:0] mk_hdr(input logic [DIG_W-1:0] dig,
      input logic [EVID_W-1:0] ev, input logic [BID_W-1:0] bx);
    return {TAG_HDR, dig, ev, bx, 2'b00};
  endfunction

  function automatic logic [WORD_W-1:0] mk_dat(input logic [DIG_W-1:0] dig,
      input logic [CHAN_W-1:0] ch, input logic [TIME_W-1:0] t);
    return {TAG_DAT, dig, ch, t};
  endfunction

  function automatic logic [WORD_W-1:0] mk_trl(input logic [DIG_W-1:0] dig,
      input logic err, input logic [CNT_W-1:0] n);
    return {TAG_TRL, dig, err, {PAD_W{1'b0}}, n};
  endfunction
endpackage

// File: rtl/twp_fifo.sv
module twp_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH < 2) ? 1 : $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_p, rd_p;
  logic [CW-1:0] cnt;

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign dout  = mem[rd_p];

  always_ff @(posedge clk) begin
    if (push) mem[wr_p] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_p <= '0;
      rd_p <= '0;
      cnt  <= '0;
    end else begin
      if (push) wr_p <= (wr_p == AW'(DEPTH - 1)) ? '0 : wr_p + 1'b1;
      if (pop)  rd_p <= (rd_p == AW'(DEPTH - 1)) ? '0 : rd_p + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  assert_no_push_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop));
  assert_no_pop_empty_R12: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
endmodule

// File: rtl/twp_win.sv
module twp_win #(
  parameter int TW = 19
) (
  input  logic [TW-1:0] hit_t,
  input  logic [TW-1:0] trig_t,
  input  logic [TW-1:0] win,
  output logic          is_old,
  output logic          is_match
);
  logic [TW-1:0] rel;
  // Offset of the hit from the window start, modulo 2^TW.
  assign rel      = hit_t - (trig_t - win);
  assign is_old   = rel[TW-1];
  assign is_match = !rel[TW-1] && (rel < win);
endmodule

// File: rtl/twp_packer.sv
module twp_packer
  import twp_pkg::*;
#(
  parameter int         HB_DEPTH = 8,
  parameter int         TQ_DEPTH = 4,
  parameter logic [3:0] DIG_ID   = 4'h5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                match_en,
  input  logic [TIME_W-1:0]   cfg_window,
  input  logic [TIME_W-1:0]   cfg_search,
  input  logic                trig,
  input  logic [EVID_W-1:0]   ev_id,
  input  logic [BID_W-1:0]    bunch_id,
  output logic [TIME_W-1:0]   time_now,
  input  logic                hit_valid,
  output logic                hit_ready,
  input  logic [CHAN_W-1:0]   hit_chan,
  input  logic [TIME_W-1:0]   hit_time,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [WORD_W-1:0]   out_data
);
  localparam int TW   = TIME_W;
  localparam int HB_W = CHAN_W + TW;
  localparam int TQ_W = TW + EVID_W + BID_W;

  pk_state_t          st;
  logic [TW-1:0]      tcnt, cur_t;
  logic [EVID_W-1:0]  cur_ev, rej_ev;
  logic [BID_W-1:0]   cur_b, rej_b;
  logic               is_rej, rej_v, err_st, trl_err;
  logic [CNT_W-1:0]   cnt;

  logic               hb_push, hb_pop, hb_full, hb_empty, hb_ovf;
  logic [HB_W-1:0]    hb_q;
  logic               tq_push, tq_pop, tq_full, tq_empty;
  logic [TQ_W-1:0]    tq_q;
  logic               trig_acc, rej_store, trig_lost;
  logic               h_old, h_match, guard_ok, enter_trl;
  logic [TW-1:0]      guard, elapsed;

  assign time_now  = tcnt;
  assign hit_ready = !hb_full;
  assign hb_push   = hit_valid && !hb_full;
  assign hb_ovf    = hit_valid && hb_full;

  assign trig_acc  = trig && match_en;
  assign tq_push   = trig_acc && !tq_full;
  assign rej_store = trig_acc && tq_full && !rej_v;
  assign trig_lost = trig_acc && tq_full && rej_v;
  assign tq_pop    = (st == S_IDLE) && match_en && !rej_v && !tq_empty;

  assign guard     = cfg_search - cfg_window;
  assign elapsed   = tcnt - cur_t;
  assign guard_ok  = (elapsed >= guard);

  twp_fifo #(.W(HB_W), .DEPTH(HB_DEPTH)) u_hitbuf (
    .clk(clk), .rst_n(rst_n), .push(hb_push), .din({hit_chan, hit_time}),
    .pop(hb_pop), .dout(hb_q), .full(hb_full), .empty(hb_empty));

  twp_fifo #(.W(TQ_W), .DEPTH(TQ_DEPTH)) u_trigq (
    .clk(clk), .rst_n(rst_n), .push(tq_push), .din({tcnt, ev_id, bunch_id}),
    .pop(tq_pop), .dout(tq_q), .full(tq_full), .empty(tq_empty));

  twp_win #(.TW(TW)) u_win (
    .hit_t(hb_q[TW-1:0]), .trig_t(cur_t), .win(cfg_window),
    .is_old(h_old), .is_match(h_match));

  always_comb begin
    enter_trl = 1'b0;
    if (st == S_HDR && out_ready && is_rej) enter_trl = 1'b1;
    if (st == S_SCAN && (hb_empty || (!h_old && !h_match))) enter_trl = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcnt    <= '0;
      st      <= S_IDLE;
      cur_t   <= '0;
      cur_ev  <= '0;
      cur_b   <= '0;
      is_rej  <= 1'b0;
      rej_v   <= 1'b0;
      rej_ev  <= '0;
      rej_b   <= '0;
      err_st  <= 1'b0;
      trl_err <= 1'b0;
      cnt     <= '0;
    end else begin
      tcnt   <= tcnt + 1'b1;
      err_st <= (err_st && !enter_trl) || hb_ovf || trig_lost;
      if (enter_trl) trl_err <= is_rej || err_st;
      if (rej_store) begin
        rej_v  <= 1'b1;
        rej_ev <= ev_id;
        rej_b  <= bunch_id;
      end
      case (st)
        S_IDLE: if (match_en) begin
          if (rej_v) begin
            cur_ev <= rej_ev;
            cur_b  <= rej_b;
            is_rej <= 1'b1;
            rej_v  <= 1'b0;
            cnt    <= '0;
            st     <= S_HDR;
          end else if (!tq_empty) begin
            {cur_t, cur_ev, cur_b} <= tq_q;
            is_rej <= 1'b0;
            cnt    <= '0;
            st     <= S_WAIT;
          end
        end
        S_WAIT: if (guard_ok) st <= S_HDR;
        S_HDR:  if (out_ready) st <= is_rej ? S_TRL : S_SCAN;
        S_SCAN: begin
          if (enter_trl) st <= S_TRL;
          else if (h_match && out_ready) cnt <= cnt + 1'b1;
        end
        S_TRL:  if (out_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    hb_pop    = 1'b0;
    out_valid = 1'b0;
    out_data  = mk_dat(DIG_ID, hb_q[HB_W-1:TW], hb_q[TW-1:0]);
    case (st)
      S_IDLE: if (!match_en) begin
        out_valid = !hb_empty;
        hb_pop    = !hb_empty && out_ready;
      end
      S_HDR: begin
        out_valid = 1'b1;
        out_data  = mk_hdr(DIG_ID, cur_ev, cur_b);
      end
      S_SCAN: if (!hb_empty) begin
        if (h_old) hb_pop = 1'b1;
        else if (h_match) begin
          out_valid = 1'b1;
          hb_pop    = out_ready;
        end
      end
      S_TRL: begin
        out_valid = 1'b1;
        out_data  = mk_trl(DIG_ID, trl_err, cnt);
      end
      default: ;
    endcase
  end

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && $stable(match_en)) |=> (out_valid && $stable(out_data)));
  assert_rej_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TRL && is_rej) |-> (cnt == '0 && trl_err));
  assert_no_frame_raw_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_data[WORD_W-1 -: 2] != TAG_DAT) |-> match_en);
  assert_tag_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data[WORD_W-1 -: 2] != 2'b00));
  assert_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HDR && !is_rej) |-> ((tcnt - cur_t) >= (cfg_search - cfg_window)));
  assert_data_in_win_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SCAN && out_valid) |-> ((out_data[TW-1:0] - cur_t + cfg_window) < cfg_window));
endmodule

// File: tb/twp_packer_tb.sv
`timescale 1ns/1ps
module twp_packer_tb;
  localparam logic [3:0] DIG = 4'hA;
  localparam int WIN = 40;
  localparam int SRCH = 50;
  // rows: hit offset from trigger time, kind (0 old, 1 match, 2 newer)
  localparam int VEC [7][2] = '{'{-41, 0}, '{-40, 1}, '{-1, 1}, '{0, 2},
                                '{-5, 1}, '{7, 2}, '{-100, 0}};

  logic clk = 0, rst_n = 0, match_en = 1, trig = 0;
  logic [18:0] cfg_window = 19'(WIN), cfg_search = 19'(SRCH);
  logic [11:0] ev_id = 0, bunch_id = 0;
  logic [18:0] time_now;
  logic hit_valid = 0, hit_ready;
  logic [6:0] hit_chan = 0;
  logic [18:0] hit_time = 0;
  logic out_valid, out_ready = 0;
  logic [31:0] out_data;

  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] gw [32];
  int nw;
  logic [18:0] gt;

  always #2 clk = ~clk;

  twp_packer #(.HB_DEPTH(4), .TQ_DEPTH(2), .DIG_ID(DIG)) u_dut (
    .clk(clk), .rst_n(rst_n), .match_en(match_en), .cfg_window(cfg_window),
    .cfg_search(cfg_search), .trig(trig), .ev_id(ev_id), .bunch_id(bunch_id),
    .time_now(time_now), .hit_valid(hit_valid), .hit_ready(hit_ready),
    .hit_chan(hit_chan), .hit_time(hit_time), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data));

  function automatic logic [31:0] e_hdr(input logic [11:0] ev, input logic [11:0] b);
    return {2'b10, DIG, ev, b, 2'b00};
  endfunction
  function automatic logic [31:0] e_dat(input logic [6:0] c, input logic [18:0] t);
    return {2'b01, DIG, c, t};
  endfunction
  function automatic logic [31:0] e_trl(input logic e, input logic [11:0] n);
    return {2'b11, DIG, e, 13'b0, n};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_hit(input logic [6:0] c, input logic [18:0] t);
    @(negedge clk);
    hit_valid = 1; hit_chan = c; hit_time = t;
    @(negedge clk);
    hit_valid = 0;
  endtask

  task automatic trig_at(input logic [18:0] t, input logic [11:0] ev, input logic [11:0] b);
    do @(negedge clk); while (time_now != t);
    trig = 1; ev_id = ev; bunch_id = b;
    @(negedge clk);
    trig = 0;
  endtask

  task automatic grab(input bit until_trl, input int nmax);
    int k = 0;
    nw = 0;
    while (nw < nmax && k < 3000) begin
      @(negedge clk);
      k++;
      out_ready = (k % 3 != 1);
      #1;
      if (out_valid && out_ready) begin
        if (nw == 0) gt = time_now;
        gw[nw] = out_data;
        nw++;
        if (until_trl && out_data[31:30] == 2'b11) break;
      end
    end
    @(negedge clk);
    out_ready = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [18:0] t0, ht, t1;
    repeat (5) @(negedge clk);
    #1;
    chk(out_valid == 0, "R1 out_valid in reset", out_valid, 0);
    rst_n = 1;
    @(negedge clk); #1;
    chk(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
    chk(hit_ready == 1, "R1 hit_ready after reset", hit_ready, 1);
    t1 = time_now;
    @(negedge clk); #1;
    chk(time_now == t1 + 1, "R1 time counts", time_now, t1 + 1);
    repeat (200) @(negedge clk);

    // table walk: R2, R3, R4, R5, R6
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      t0 = time_now + 19'd8;
      ht = t0 + 19'(VEC[i][0]);
      push_hit(7'(i + 1), ht);
      trig_at(t0, 12'(40 + i), 12'(80 + i));
      grab(1, 8);
      chk(gw[0] == e_hdr(12'(40 + i), 12'(80 + i)), "R5 header ids", gw[0], e_hdr(12'(40 + i), 12'(80 + i)));
      chk(19'(gt - t0) >= 19'(SRCH - WIN), "R6 guard", 19'(gt - t0), SRCH - WIN);
      if (VEC[i][1] == 1) begin
        chk(nw == 3, "R2 matched event length", nw, 3);
        chk(gw[1] == e_dat(7'(i + 1), ht), "R2 data word", gw[1], e_dat(7'(i + 1), ht));
        chk(gw[2] == e_trl(0, 1), "R4 trailer count", gw[2], e_trl(0, 1));
      end else begin
        chk(nw == 2, "R3 unmatched event length", nw, 2);
        chk(gw[1] == e_trl(0, 0), "R4 empty trailer", gw[1], e_trl(0, 0));
      end
      if (VEC[i][1] == 2) begin
        trig_at(ht + 19'(WIN), 12'(60 + i), 12'(90 + i));
        grab(1, 8);
        chk(nw == 3 && gw[1] == e_dat(7'(i + 1), ht), "R3 newer hit retained", gw[1], e_dat(7'(i + 1), ht));
      end
    end

    // ordering and mixed ages: R12, R3
    @(negedge clk);
    t0 = time_now + 19'd12;
    push_hit(7'd1, t0 - 19'd45);
    push_hit(7'd2, t0 - 19'd30);
    push_hit(7'd3, t0 - 19'd3);
    push_hit(7'd4, t0 + 19'd2);
    trig_at(t0, 12'd200, 12'd201);
    grab(1, 8);
    chk(nw == 4, "R12 event length", nw, 4);
    chk(gw[1] == e_dat(7'd2, t0 - 19'd30), "R12 first data", gw[1], e_dat(7'd2, t0 - 19'd30));
    chk(gw[2] == e_dat(7'd3, t0 - 19'd3), "R12 second data", gw[2], e_dat(7'd3, t0 - 19'd3));
    chk(gw[3] == e_trl(0, 2), "R4 trailer count two", gw[3], e_trl(0, 2));
    trig_at(t0 + 19'd2 + 19'd45, 12'd202, 12'd203);
    grab(1, 8);
    chk(nw == 2 && gw[1] == e_trl(0, 0), "R3 old hit dropped", gw[1], e_trl(0, 0));

    // hit buffer overflow: R8
    @(negedge clk);
    t0 = time_now + 19'd12;
    for (int j = 0; j < 5; j++) begin
      if (j == 4) chk(hit_ready == 0, "R8 ready low when full", hit_ready, 0);
      hit_valid = 1; hit_chan = 7'(j); hit_time = t0 + 19'd100 + 19'(j);
      @(negedge clk);
    end
    hit_valid = 0;
    trig_at(t0, 12'd300, 12'd301);
    grab(1, 8);
    chk(nw == 2 && gw[1] == e_trl(1, 0), "R8 error after overflow", gw[1], e_trl(1, 0));
    @(negedge clk);
    trig_at(time_now + 19'd3, 12'd302, 12'd303);
    grab(1, 8);
    chk(nw == 2 && gw[1] == e_trl(0, 0), "R8 error cleared", gw[1], e_trl(0, 0));
    trig_at(t0 + 19'd104 + 19'd45, 12'd304, 12'd305);
    grab(1, 8);
    chk(nw == 2 && gw[1] == e_trl(0, 0), "R3 flush drops old hits", gw[1], e_trl(0, 0));
    chk(hit_ready == 1, "R8 buffer drained", hit_ready, 1);

    // trigger queue saturation: R9, R10
    @(negedge clk);
    for (int j = 0; j < 5; j++) begin
      trig = 1; ev_id = 12'(10 + j); bunch_id = 12'(20 + j);
      @(negedge clk);
    end
    trig = 0;
    begin
      logic [11:0] eo [4] = '{12'd10, 12'd13, 12'd11, 12'd12};
      logic        ee [4] = '{1'b1, 1'b1, 1'b0, 1'b0};
      for (int j = 0; j < 4; j++) begin
        grab(1, 8);
        chk(gw[0] == e_hdr(eo[j], eo[j] + 12'd10), "R9 event order", gw[0], e_hdr(eo[j], eo[j] + 12'd10));
        chk(nw == 2 && gw[1] == e_trl(ee[j], 0), "R10 trailer error", gw[1], e_trl(ee[j], 0));
      end
    end

    // raw forwarding: R7
    @(negedge clk);
    match_en = 0;
    push_hit(7'd9, 19'd1234);
    push_hit(7'd8, 19'd77);
    push_hit(7'd7, 19'd5000);
    grab(0, 3);
    chk(nw == 3, "R7 raw count", nw, 3);
    chk(gw[0] == e_dat(7'd9, 19'd1234), "R7 raw word 0", gw[0], e_dat(7'd9, 19'd1234));
    chk(gw[1] == e_dat(7'd8, 19'd77), "R7 raw word 1", gw[1], e_dat(7'd8, 19'd77));
    chk(gw[2] == e_dat(7'd7, 19'd5000), "R7 raw word 2", gw[2], e_dat(7'd7, 19'd5000));
    @(negedge clk);
    trig = 1; ev_id = 12'd500;
    @(negedge clk);
    trig = 0;
    begin
      int seen = 0;
      for (int j = 0; j < 80; j++) begin
        @(negedge clk); #1;
        if (out_valid) seen++;
      end
      chk(seen == 0, "R7 trigger ignored", seen, 0);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule